// File: doc/BRIEF.md
# I2C Write-Only Slave with Receive Clock Stretching

This block is an I2C target that only accepts writes, using 7-bit addressing. It brings the bus lines into the system clock domain and finds start and stop conditions there. It shifts in each byte on SCL rising edges. It answers in the ninth clock slot with an acknowledge or a not-acknowledge. Each accepted byte lands in a one-byte holding register that the host drains.

The host side has four things. It sees a buffer-full flag, a sticky overflow flag and a sticky interrupt flag. It also owns a clock-release bit. With stretching enabled, the block decides at the falling edge of the ninth clock whether to hold SCL low. It holds SCL only if the byte was acknowledged and the host has not yet emptied the buffer. SCL then stays low until the host writes the release bit.

Both bus lines are open-drain. The block only ever pulls a line low or lets it go.

Top module: `i2c_rx_stretch`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins an address byte. A stop condition (SDA rising while SCL is high) returns the block to idle with both line drivers released, even in the middle of a byte.
- R2: The first byte after a start is acknowledged only if its upper seven bits (sent MSB first) equal `SLAVE_ADDR` and its lowest bit, the read/write bit, is 0. Otherwise SDA is left high in the ninth slot, nothing is stored, and every byte up to the next start or stop is also left unacknowledged.
- R3: Every acknowledged byte is stored in `rx_data` and sets `buf_full`. The address byte is stored with its read/write bit in bit 0. A pulse on `rd_strobe` clears `buf_full`.
- R4: `irq_flag` is set at the ninth falling edge of every acknowledged byte. It stays set until `irq_clr` is pulsed.
- R5: When `stretch_en` is 1 and `buf_full` is still 1 at the ninth falling edge of an acknowledged byte, `release_bit` goes to 0 and `scl_drive_low` is asserted.
- R6: A held SCL stays low, for any length of time, until the host pulses `rel_wr`. `release_bit` then returns to 1 and SCL is let go.
- R7: If the host reads the buffer during the ninth clock, before its falling edge, no stretch occurs and `release_bit` stays 1.
- R8: A byte that completes while `buf_full` is 1 sets `ovf_flag`. It is not acknowledged, it leaves `rx_data` unchanged, and no stretch follows it.
- R9: While `ovf_flag` is 1, bytes are neither acknowledged nor stored, even if the buffer is empty. `ovf_clr` clears the flag, and reception then resumes.
- R10: With `stretch_en` at 0, SCL is never held, whatever the buffer state.
- R11: `sda_drive_low` is asserted only in the acknowledge slot, and it changes only while SCL is low.
- R12: After reset, `buf_full`, `ovf_flag`, `irq_flag` and both line drivers are 0, and `release_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| stretch_en | input | 1 | Enables holding SCL after acknowledged bytes |
| rd_strobe | input | 1 | Host read of the holding buffer (clears buffer-full) |
| rel_wr | input | 1 | Host write of 1 to the clock-release bit |
| irq_clr | input | 1 | Host clear of the interrupt flag |
| ovf_clr | input | 1 | Host clear of the overflow flag |
| rx_data | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Holding buffer holds an unread byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| release_bit | output | 1 | Clock-release bit (0 while SCL is held) |

## Verification
A vector table drives complete write transfers, each row varying four things: the address, the read/write bit, the data value, and whether the host drains the buffer inside the ninth clock or only afterwards, with stretching on or off. Rows with a matching address separate three outcomes: a stretch, the early-read escape that avoids one, and stretching disabled. Rows with a wrong address or the read bit set show the ignore path. Directed sequences then follow. One stops a transfer partway through a byte. Another leaves the buffer unread so that the overflow, its missing stretch and its sticky rejection show up. A third holds SCL through a long host delay.

// File: rtl/i2c_rx_pkg.sv
// Package: shared types for the I2C write-only slave.
// Assumes nothing beyond the IEEE 1800-2017 language.
package i2c_rx_pkg;

    // Receive engine states
    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer addressed to this block
        ST_ADDR,   // shifting the address byte
        ST_DATA,   // shifting a data byte
        ST_ACK,    // ninth clock slot
        ST_SKIP    // addressed elsewhere, wait for start or stop
    } rx_state_e;

    // Bus events in the system clock domain
    typedef struct packed {
        logic scl;       // synchronised SCL level
        logic sda;       // synchronised SDA level
        logic scl_rise;  // SCL went high this cycle
        logic scl_fall;  // SCL went low this cycle
        logic start;     // SDA fell with SCL high
        logic stop;      // SDA rose with SCL high
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clk domain through SYNC_STAGES flops,
// then derives edge, start and stop events from one extra flop stage.
// Assumes: lines idle high; no glitch filtering is done.
module i2c_line_sync
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;
    logic          scl_p;
    logic          sda_p;

    // Synchroniser chains, reset to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[LAST-1:0], scl_in};
            sda_ff <= {sda_ff[LAST-1:0], sda_in};
        end
    end

    // One-cycle history used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_ff[LAST];
            sda_p <= sda_ff[LAST];
        end
    end

    // Event decode from the current and previous synchronised samples
    always_comb begin
        evt.scl      = scl_ff[LAST];
        evt.sda      = sda_ff[LAST];
        evt.scl_rise = scl_ff[LAST] & ~scl_p;
        evt.scl_fall = ~scl_ff[LAST] & scl_p;
        evt.start    = scl_ff[LAST] & scl_p & sda_p & ~sda_ff[LAST];
        evt.stop     = scl_ff[LAST] & scl_p & ~sda_p & sda_ff[LAST];
    end

endmodule

// File: rtl/i2c_rx_engine.sv
// Module: i2c_rx_engine
// Shifts bits on SCL rising edges, matches the address byte and
// decides ACK or NACK at the eighth falling edge. It drives SDA low
// through the ninth clock and flags the end of that slot.
// Assumes: bus events come from i2c_line_sync; buffer and overflow
// state come from the host interface.
module i2c_rx_engine
    import i2c_rx_pkg::*;
#(
    parameter int                ADDR_W     = 7,
    parameter int                BYTE_W     = 8,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              bf,
    input  logic              ovf,
    output logic              byte_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ovf_set,
    output logic              ack_given,
    output logic              sda_low
);

    localparam int             CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              acked;
    logic              was_addr;
    logic              seen_rise;

    logic byte_done;
    logic addr_hit;
    logic wanted;
    logic accept_ok;
    logic slot_end;

    // Decisions taken when a byte completes or a slot ends
    always_comb begin
        byte_done = evt.scl_fall && (cnt == CNT_END) && !evt.start && !evt.stop
                    && ((state == ST_ADDR) || (state == ST_DATA));
        addr_hit  = (shreg[BYTE_W-1 -: ADDR_W] == SLAVE_ADDR) && !shreg[0];
        wanted    = (state == ST_DATA) || addr_hit;
        accept_ok = wanted && !bf && !ovf;
        byte_load = byte_done && accept_ok;
        ovf_set   = byte_done && wanted && bf;
        slot_end  = (state == ST_ACK) && evt.scl_fall && seen_rise
                    && !evt.start && !evt.stop;
        ack_given = slot_end && acked;
        rx_byte   = shreg;
        sda_low   = (state == ST_ACK) && acked;
    end

    // State, bit count and slot bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            acked     <= 1'b0;
            was_addr  <= 1'b0;
            seen_rise <= 1'b0;
        end else if (evt.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
            acked <= 1'b0;
        end else if (evt.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
            acked <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_DATA: begin
                    if (evt.scl_rise && (cnt != CNT_END)) begin
                        cnt <= cnt + 1'b1;
                    end
                    if (byte_done) begin
                        state     <= ST_ACK;
                        acked     <= accept_ok;
                        was_addr  <= (state == ST_ADDR);
                        seen_rise <= 1'b0;
                    end
                end
                ST_ACK: begin
                    if (evt.scl_rise) begin
                        seen_rise <= 1'b1;
                    end
                    if (slot_end) begin
                        state <= (was_addr && !acked) ? ST_SKIP : ST_DATA;
                        cnt   <= '0;
                        acked <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Shift register, MSB first on SCL rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (evt.scl_rise && (cnt != CNT_END)
                     && ((state == ST_ADDR) || (state == ST_DATA))) begin
            shreg <= {shreg[BYTE_W-2:0], evt.sda};
        end
    end

endmodule

// File: rtl/i2c_host_if.sv
// Module: i2c_host_if
// Holding buffer and host-visible flags: buffer-full, overflow,
// interrupt and the clock-release bit. Set events win over host clears.
// Assumes: event inputs are single-cycle pulses from i2c_rx_engine.
module i2c_host_if #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_load,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ovf_set,
    input  logic              ack_given,
    input  logic              stretch_en,
    input  logic              rd_strobe,
    input  logic              rel_wr,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] data_q,
    output logic              bf,
    output logic              ovf,
    output logic              irq,
    output logic              ckp
);

    // Holding buffer captures accepted bytes
    always_ff @(posedge clk) begin
        if (!rst_n)         data_q <= '0;
        else if (byte_load) data_q <= rx_byte;
    end

    // Buffer-full: set on load, cleared by a host read
    always_ff @(posedge clk) begin
        if (!rst_n)         bf <= 1'b0;
        else if (byte_load) bf <= 1'b1;
        else if (rd_strobe) bf <= 1'b0;
    end

    // Overflow: sticky until the host clears it
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_set) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // Interrupt: set per acknowledged byte, sticky until cleared
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (ack_given) irq <= 1'b1;
        else if (irq_clr)   irq <= 1'b0;
    end

    // Clock-release bit: forced low on a stretch decision, set by host
    always_ff @(posedge clk) begin
        if (!rst_n)                           ckp <= 1'b1;
        else if (ack_given && stretch_en && bf) ckp <= 1'b0;
        else if (rel_wr)                      ckp <= 1'b1;
    end

endmodule

// File: rtl/i2c_rx_stretch.sv
// Module: i2c_rx_stretch (top)
// Write-only I2C slave with a one-byte holding buffer and optional
// SCL hold after acknowledged bytes.
// Assumes: scl_in/sda_in are the wired-AND line levels; the outputs
// control open-drain pull-downs and never drive a line high.
module i2c_rx_stretch #(
    parameter int                ADDR_W      = 7,
    parameter int                BYTE_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              stretch_en,
    input  logic              rd_strobe,
    input  logic              rel_wr,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf_flag,
    output logic              irq_flag,
    output logic              release_bit
);

    i2c_rx_pkg::bus_evt_t evt;
    logic              byte_load;
    logic [BYTE_W-1:0] rx_byte;
    logic              ovf_set;
    logic              ack_given;
    logic              sda_low;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_rx_engine #(
        .ADDR_W     (ADDR_W),
        .BYTE_W     (BYTE_W),
        .SLAVE_ADDR (SLAVE_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .bf        (buf_full),
        .ovf       (ovf_flag),
        .byte_load (byte_load),
        .rx_byte   (rx_byte),
        .ovf_set   (ovf_set),
        .ack_given (ack_given),
        .sda_low   (sda_low)
    );

    i2c_host_if #(.BYTE_W(BYTE_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_load  (byte_load),
        .rx_byte    (rx_byte),
        .ovf_set    (ovf_set),
        .ack_given  (ack_given),
        .stretch_en (stretch_en),
        .rd_strobe  (rd_strobe),
        .rel_wr     (rel_wr),
        .irq_clr    (irq_clr),
        .ovf_clr    (ovf_clr),
        .data_q     (rx_data),
        .bf         (buf_full),
        .ovf        (ovf_flag),
        .irq        (irq_flag),
        .ckp        (release_bit)
    );

    // Open-drain pull-down controls
    always_comb begin
        scl_drive_low = ~release_bit;
        sda_drive_low = sda_low;
    end

endmodule

// File: rtl/i2c_rx_stretch_chk.sv
// Module: i2c_rx_stretch_chk
// Temporal checks on the top module's ports and internal load pulse,
// attached by bind.
module i2c_rx_stretch_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic rel_wr,
    input logic rd_strobe,
    input logic byte_load,
    input logic buf_full,
    input logic ovf_flag,
    input logic ovf_clr,
    input logic irq_flag,
    input logic irq_clr
);

    // R6: a held clock stays held until the host releases it
    a_r6_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !rel_wr) |=> scl_drive_low);

    // R11: SDA pull-down changes only while SCL is low
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_in);

    // R8: overflow flag is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R8: the byte that overflows is followed by no stretch
    a_r8_no_stretch_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |=> !scl_drive_low);

    // R4: interrupt flag is sticky
    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R3: a host read without a simultaneous load empties the buffer
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !byte_load) |=> !buf_full);

endmodule

bind i2c_rx_stretch i2c_rx_stretch_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .rel_wr        (rel_wr),
    .rd_strobe     (rd_strobe),
    .byte_load     (byte_load),
    .buf_full      (buf_full),
    .ovf_flag      (ovf_flag),
    .ovf_clr       (ovf_clr),
    .irq_flag      (irq_flag),
    .irq_clr       (irq_clr)
);

// File: tb/i2c_rx_stretch_test.sv
// Bench: an I2C master model on wired-AND lines plus a host model.
module i2c_rx_stretch_test;

    localparam int HP = 8;  // master half-phase in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic stretch_en = 1'b0;
    logic rd_strobe = 1'b0;
    logic rel_wr = 1'b0;
    logic irq_clr = 1'b0;
    logic ovf_clr = 1'b0;
    logic scl_drive_low, sda_drive_low;
    logic [7:0] rx_data;
    logic buf_full, ovf_flag, irq_flag, release_bit;
    logic scl_line, sda_line;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_rx_stretch uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .stretch_en    (stretch_en),
        .rd_strobe     (rd_strobe),
        .rel_wr        (rel_wr),
        .irq_clr       (irq_clr),
        .ovf_clr       (ovf_clr),
        .rx_data       (rx_data),
        .buf_full      (buf_full),
        .ovf_flag      (ovf_flag),
        .irq_flag      (irq_flag),
        .release_bit   (release_bit)
    );

    // Row fields: [20:14] address, [13] r/w, [12:5] data, [4] stretch_en,
    // [3] read inside ninth clock, [2] addr ack, [1] data ack, [0] stretch
    localparam int NV = 7;
    localparam logic [20:0] VEC [NV] = '{
        {7'h52, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'h52, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {7'h52, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {7'h53, 1'b0, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {7'h52, 1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {7'h52, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'h52, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic wait_scl_high();
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; cyc(HP);
        sda_m = 1'b0; cyc(HP);
        scl_m = 1'b0; cyc(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(HP);
        wait_scl_high(); cyc(HP);
        sda_m = 1'b1; cyc(HP);
    endtask

    task automatic send_bit(input logic v);
        sda_m = v; cyc(HP);
        wait_scl_high(); cyc(HP);
        scl_m = 1'b0; cyc(HP);
    endtask

    // Eight bits then the ninth slot; returns ack, buffer seen and stretch
    task automatic send_byte(input logic [7:0] b, input bit pre_rd,
                             output bit ack, output logic [7:0] seen, output bit str);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; cyc(HP);
        wait_scl_high(); cyc(HP / 2);
        ack  = !sda_line;
        seen = rx_data;
        if (pre_rd) pulse(rd_strobe);
        cyc(HP / 2);
        scl_m = 1'b0; cyc(HP);
        str = scl_drive_low;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        bit ack, str;
        logic [7:0] seen, abyte, dbyte;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R12: reset state
        chk("R12 buf_full", buf_full, 0);
        chk("R12 ovf", ovf_flag, 0);
        chk("R12 irq", irq_flag, 0);
        chk("R12 release", release_bit, 1);
        chk("R12 drives", {scl_drive_low, sda_drive_low}, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            abyte      = {VEC[v][20:14], VEC[v][13]};
            dbyte      = VEC[v][12:5];
            stretch_en = VEC[v][4];
            bus_start();
            send_byte(abyte, VEC[v][3], ack, seen, str);
            chk("R2 address ack", ack, VEC[v][2]);
            if (VEC[v][2]) begin
                chk("R3 address stored", seen, abyte);
                chk("R4 irq after address", irq_flag, 1);
                chk("R5 R7 R10 address stretch", str, VEC[v][0]);
                chk("R5 release bit", release_bit, !VEC[v][0]);
                if (!VEC[v][3]) pulse(rd_strobe);
                chk("R3 read clears", buf_full, 0);
                pulse(irq_clr);
                if (str) pulse(rel_wr);
                chk("R6 released", scl_drive_low, 0);
            end else begin
                chk("R2 nothing stored", buf_full, 0);
            end
            send_byte(dbyte, VEC[v][3], ack, seen, str);
            chk("R2 data ack", ack, VEC[v][1]);
            if (VEC[v][1]) begin
                chk("R3 data stored", seen, dbyte);
                chk("R5 R7 R10 data stretch", str, VEC[v][0]);
                if (!VEC[v][3]) pulse(rd_strobe);
                pulse(irq_clr);
                if (str) pulse(rel_wr);
            end else begin
                chk("R2 ignored data", {buf_full, scl_drive_low}, 0);
            end
            bus_stop();
            chk("R1 idle after stop", {scl_drive_low, sda_drive_low}, 0);
        end

        // R1: stop in the middle of an address byte, then a full transfer
        stretch_en = 1'b0;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        chk("R1 abort leaves idle", {buf_full, sda_drive_low}, 0);
        bus_start();
        send_byte(8'hA4, 1'b1, ack, seen, str);
        chk("R1 new start acked", ack, 1);
        bus_stop();
        pulse(irq_clr);

        // R6: long hold, R8: overflow, R9: sticky rejection
        stretch_en = 1'b1;
        bus_start();
        send_byte(8'hA4, 1'b0, ack, seen, str);
        chk("R5 stretch on full buffer", str, 1);
        cyc(300);
        chk("R6 still held", {scl_drive_low, release_bit}, 2'b10);
        chk("R4 irq held without clear", irq_flag, 1);
        pulse(irq_clr);
        chk("R4 irq cleared", irq_flag, 0);
        pulse(rel_wr);
        chk("R6 release", {scl_drive_low, release_bit}, 2'b01);
        send_byte(8'h5A, 1'b0, ack, seen, str);
        chk("R8 nack", ack, 0);
        chk("R8 ovf set", ovf_flag, 1);
        chk("R8 buffer kept", rx_data, 8'hA4);
        chk("R8 no stretch", str, 0);
        chk("R4 no irq on nack", irq_flag, 0);
        pulse(rd_strobe);
        send_byte(8'h66, 1'b0, ack, seen, str);
        chk("R9 nack while ovf", ack, 0);
        chk("R9 not stored", {buf_full, rx_data}, {1'b0, 8'hA4});
        pulse(ovf_clr);
        chk("R9 ovf cleared", ovf_flag, 0);
        stretch_en = 1'b0;
        send_byte(8'hC3, 1'b0, ack, seen, str);
        chk("R9 accepted again", {ack, seen}, {1'b1, 8'hC3});
        chk("R10 no stretch with full buffer", str, 0);
        bus_stop();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule